// File: doc/BRIEF.md
# Special-Area Read Mode Controller

This block decides whether a read of the code-memory window goes to the main array or to one of two special areas: a factory-programmed identifier and a user signature area. Software sends a start command for one area. After a fixed entry delay the ready flag drops. From then on, reads at the base of the window go to that area. A matching stop command, after a fixed exit delay, brings the ready flag back up. If the interrupt enable is set, the rising ready flag also raises an interrupt. The interrupt stays high until software reads the status.

The block registers each read request for one cycle. It then drives exactly one source strobe together with the address for that source, and it returns the data from the selected source on the same cycle. The array itself, the identifier store and the signature store sit outside the block. While any special mode is in progress, instruction fetches are refused.

Top module: `special_read_ctrl`

## Requirements
- R1: After reset `ready` is 1 and `irq` is 0. A command with `cmd_code`=0 (start identifier), taken while idle, makes `ready` fall exactly ENTER_CYC cycles after the clock edge that captured the command.
- R2: While identifier mode is active (`ready` low), a data read at an address from BASE to BASE+ID_BYTES-1 strobes `id_re`. It places the offset from BASE on `mem_addr` and returns `id_rdata`.
- R3: In identifier mode, a command with `cmd_code`=1 (stop identifier) makes `ready` rise exactly EXIT_CYC cycles after the capture edge.
- R4: If the mode-register interrupt enable is 1, `irq` rises on the same edge on which `ready` rises at the end of a stop. If the enable is 0, `irq` stays 0.
- R5: A command with `cmd_code`=2 (start signature), taken while idle, makes `ready` fall ENTER_CYC cycles later. `cmd_code`=3 (stop signature) ends signature mode EXIT_CYC cycles later.
- R6: In signature mode, data reads from BASE to BASE+SIG_BYTES-1 strobe `sig_re` with the offset on `mem_addr`. BASE+SIG_BYTES and above go to the array.
- R7: While the controller is not idle, a read with `rd_fetch`=1 returns `rd_err`=1 and `rd_data`=0, and it strobes no source.
- R8: A start command received while not idle is ignored. A stop command that does not match the active mode is ignored.
- R9: `irq` stays 1 until a cycle with `stat_rd`=1 clears it on the next edge. If a new rise of `ready` happens on the same edge, the set wins.
- R10: Any read outside the overlaid range, and every read while idle, strobes `arr_re` with `mem_addr` equal to `rd_addr` and returns `arr_rdata`.
- R11: `rd_valid` is 1 exactly one cycle after a cycle with `rd_en`=1, and the data and strobes belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 start id, 1 stop id, 2 start signature, 3 stop signature |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_irq_en | input | 1 | Interrupt enable value written by mode_wr |
| stat_rd | input | 1 | Status read strobe, clears irq |
| ready | output | 1 | Ready flag |
| irq | output | 1 | Ready interrupt |
| rd_en | input | 1 | Read request |
| rd_fetch | input | 1 | Request is an instruction fetch |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read result valid |
| rd_err | output | 1 | Fetch refused |
| rd_data | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | Address to the selected source |
| arr_re | output | 1 | Main array strobe |
| id_re | output | 1 | Identifier store strobe |
| sig_re | output | 1 | Signature store strobe |
| arr_rdata | input | DATA_W | Array data |
| id_rdata | input | DATA_W | Identifier data |
| sig_rdata | input | DATA_W | Signature data |

## Verification
The assertions check several properties on every cycle. At most one source strobe is active at a time. A rising ready flag with the enable set comes with the interrupt. A status read clears the interrupt unless a new exit completes on the same edge. A refused fetch never reaches a source. A start command seen while busy leaves the mode unchanged. Identifier-range reads in identifier mode always reach the identifier store. Other behaviour is checked only by the bench scenarios: the exact entry and exit delays, the address offsets and the data returned, the edge between the signature area and the array, and the stop commands that do not match the active mode.

// File: rtl/special_read_ctrl.sv
module special_read_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [31:0] BASE = 32'h0040_0000,
  parameter int ID_BYTES = 1024,
  parameter int SIG_BYTES = 512,
  parameter int ENTER_CYC = 4,
  parameter int EXIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              mode_wr,
  input  logic              mode_irq_en,
  input  logic              stat_rd,
  output logic              ready,
  output logic              irq,
  input  logic              rd_en,
  input  logic              rd_fetch,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              arr_re,
  output logic              id_re,
  output logic              sig_re,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [DATA_W-1:0] id_rdata,
  input  logic [DATA_W-1:0] sig_rdata
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ID_LEN = ADDR_W'(ID_BYTES);
  localparam logic [ADDR_W-1:0] SG_LEN = ADDR_W'(SIG_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ID_IN, S_ID_ON, S_ID_OUT, S_SG_IN, S_SG_ON, S_SG_OUT} st_t;
  typedef enum logic [1:0] {SEL_NONE, SEL_ARR, SEL_ID, SEL_SG} sel_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic            irq_en_q, irq_q;
  logic            valid_q, err_q;
  sel_t            sel_q, sel_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  wire cnt_zero  = (cnt == '0);
  wire exit_done = ((st == S_ID_OUT) || (st == S_SG_OUT)) && cnt_zero;
  wire busy      = (st != S_IDLE);
  wire id_map    = (st == S_ID_ON) || (st == S_ID_OUT);
  wire sg_map    = (st == S_SG_ON) || (st == S_SG_OUT);
  wire [ADDR_W-1:0] offs = rd_addr - BASE_A;
  wire above     = (rd_addr >= BASE_A);
  wire in_id     = above && (offs < ID_LEN);
  wire in_sg     = above && (offs < SG_LEN);
  wire refuse    = rd_fetch && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid && cmd_code == 2'd0) begin
                  st <= S_ID_IN; cnt <= CW'(ENTER_CYC - 1);
                end else if (cmd_valid && cmd_code == 2'd2) begin
                  st <= S_SG_IN; cnt <= CW'(ENTER_CYC - 1);
                end
        S_ID_IN:  if (cnt_zero) st <= S_ID_ON; else cnt <= cnt - 1'b1;
        S_ID_ON:  if (cmd_valid && cmd_code == 2'd1) begin
                    st <= S_ID_OUT; cnt <= CW'(EXIT_CYC - 1);
                  end
        S_ID_OUT: if (cnt_zero) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_SG_IN:  if (cnt_zero) st <= S_SG_ON; else cnt <= cnt - 1'b1;
        S_SG_ON:  if (cmd_valid && cmd_code == 2'd3) begin
                    st <= S_SG_OUT; cnt <= CW'(EXIT_CYC - 1);
                  end
        S_SG_OUT: if (cnt_zero) st <= S_IDLE; else cnt <= cnt - 1'b1;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign ready = (st == S_IDLE) || (st == S_ID_IN) || (st == S_SG_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (mode_wr) irq_en_q <= mode_irq_en;
      if (exit_done && irq_en_q) irq_q <= 1'b1;
      else if (stat_rd)          irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    sel_d  = SEL_ARR;
    addr_d = rd_addr;
    if (refuse) begin
      sel_d  = SEL_NONE;
      addr_d = '0;
    end else if (id_map && in_id) begin
      sel_d  = SEL_ID;
      addr_d = offs;
    end else if (sg_map && in_sg) begin
      sel_d  = SEL_SG;
      addr_d = offs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      sel_q   <= SEL_NONE;
      addr_q  <= '0;
    end else begin
      valid_q <= rd_en;
      err_q   <= rd_en && refuse;
      sel_q   <= rd_en ? sel_d : SEL_NONE;
      if (rd_en) addr_q <= addr_d;
    end
  end

  assign rd_valid = valid_q;
  assign rd_err   = err_q;
  assign mem_addr = addr_q;
  assign arr_re   = (sel_q == SEL_ARR);
  assign id_re    = (sel_q == SEL_ID);
  assign sig_re   = (sel_q == SEL_SG);

  always_comb begin
    case (sel_q)
      SEL_ARR: rd_data = arr_rdata;
      SEL_ID:  rd_data = id_rdata;
      SEL_SG:  rd_data = sig_rdata;
      default: rd_data = '0;
    endcase
  end

  p_one_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_re, id_re, sig_re}));

  p_irq_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && $past(irq_en_q)) |-> irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !exit_done) |=> !irq);

  p_fetch_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_fetch && !ready) |=> (rd_err && !arr_re && !id_re && !sig_re));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_code[0] && (st == S_ID_ON || st == S_SG_ON)) |=> $stable(st));

  p_id_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_fetch && id_map && in_id) |=> (id_re && rd_valid));
endmodule

// File: tb/test_special_read_ctrl.sv
module test_special_read_ctrl;
  localparam int ENTER_CYC = 4;
  localparam int EXIT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic mode_wr = 1'b0, mode_irq_en = 1'b0, stat_rd = 1'b0;
  logic ready, irq;
  logic rd_en = 1'b0, rd_fetch = 1'b0;
  logic [31:0] rd_addr = 32'h0;
  logic rd_valid, rd_err, arr_re, id_re, sig_re;
  logic [31:0] rd_data, mem_addr, arr_rdata, id_rdata, sig_rdata;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  assign arr_rdata = {8'hAA, mem_addr[23:0]};
  assign id_rdata  = {8'h1D, mem_addr[23:0]};
  assign sig_rdata = {8'h5E, mem_addr[23:0]};

  special_read_ctrl #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) i_special_read_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mode_wr(mode_wr), .mode_irq_en(mode_irq_en), .stat_rd(stat_rd),
    .ready(ready), .irq(irq), .rd_en(rd_en), .rd_fetch(rd_fetch), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data), .mem_addr(mem_addr),
    .arr_re(arr_re), .id_re(id_re), .sig_re(sig_re),
    .arr_rdata(arr_rdata), .id_rdata(id_rdata), .sig_rdata(sig_rdata));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] code);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic set_en(logic v);
    @(negedge clk); mode_wr = 1'b1; mode_irq_en = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic read(logic [31:0] a, logic f, logic [2:0] strb, logic [31:0] ma,
                      logic [31:0] d, logic e, string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a; rd_fetch = f;
    @(negedge clk); rd_en = 1'b0; rd_fetch = 1'b0;
    chk({tag, " valid R11"}, {31'd0, rd_valid}, 32'd1);
    chk({tag, " strobes"}, {29'd0, arr_re, id_re, sig_re}, {29'd0, strb});
    chk({tag, " err"}, {31'd0, rd_err}, {31'd0, e});
    chk({tag, " data"}, rd_data, d);
    if (strb != 3'b000) chk({tag, " addr"}, mem_addr, ma);
  endtask

  task automatic enter(logic [1:0] code, string tag);
    send(code);
    repeat (ENTER_CYC - 1) @(negedge clk);
    chk({tag, " ready before entry"}, {31'd0, ready}, 32'd1);
    @(negedge clk);
    chk({tag, " ready fell"}, {31'd0, ready}, 32'd0);
  endtask

  task automatic leave(logic [1:0] code, logic exp_irq, string tag);
    send(code);
    repeat (EXIT_CYC - 1) @(negedge clk);
    chk({tag, " ready before exit"}, {31'd0, ready}, 32'd0);
    @(negedge clk);
    chk({tag, " ready rose"}, {31'd0, ready}, 32'd1);
    chk({tag, " irq R4"}, {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic t_reset();
    chk("R1 reset ready", {31'd0, ready}, 32'd1);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    read(32'h0040_0010, 1'b0, 3'b100, 32'h0040_0010, 32'hAA40_0010, 1'b0, "R10 idle read");
  endtask

  task automatic t_id_mode();
    set_en(1'b1);
    enter(2'd0, "R1 id");
    read(32'h0040_0010, 1'b0, 3'b010, 32'h10, 32'h1D00_0010, 1'b0, "R2 id low");
    read(32'h0040_03FC, 1'b0, 3'b010, 32'h3FC, 32'h1D00_03FC, 1'b0, "R2 id top");
    read(32'h0040_0400, 1'b0, 3'b100, 32'h0040_0400, 32'hAA40_0400, 1'b0, "R10 id above");
    read(32'h003F_FFFC, 1'b0, 3'b100, 32'h003F_FFFC, 32'hAA3F_FFFC, 1'b0, "R10 id below");
    leave(2'd1, 1'b1, "R3 id");
    @(negedge clk);
    chk("R9 irq held", {31'd0, irq}, 32'd1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_sig_mode();
    set_en(1'b0);
    enter(2'd2, "R5 sig");
    read(32'h0040_0000, 1'b0, 3'b001, 32'h0, 32'h5E00_0000, 1'b0, "R6 sig base");
    read(32'h0040_01FC, 1'b0, 3'b001, 32'h1FC, 32'h5E00_01FC, 1'b0, "R6 sig top");
    read(32'h0040_0200, 1'b0, 3'b100, 32'h0040_0200, 32'hAA40_0200, 1'b0, "R6 sig edge");
    leave(2'd3, 1'b0, "R5 sig");
  endtask

  task automatic t_ignore();
    enter(2'd0, "R8 setup");
    send(2'd2);
    read(32'h0040_0300, 1'b0, 3'b010, 32'h300, 32'h1D00_0300, 1'b0, "R8 start ignored");
    send(2'd3);
    repeat (EXIT_CYC + 2) @(negedge clk);
    chk("R8 wrong stop ready", {31'd0, ready}, 32'd0);
    read(32'h0040_0008, 1'b0, 3'b010, 32'h8, 32'h1D00_0008, 1'b0, "R8 still id");
    read(32'h0040_0008, 1'b1, 3'b000, 32'h0, 32'h0, 1'b1, "R7 fetch refused");
    leave(2'd1, 1'b0, "R8 exit");
    read(32'h0040_0008, 1'b1, 3'b100, 32'h0040_0008, 32'hAA40_0008, 1'b0, "R7 fetch idle ok");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id_mode();
    t_sig_mode();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule